// File: doc/BRIEF.md
# Line-Synchronous System Tick Generator

This block produces the heartbeat that every controller on the chip uses to stay in step. A square-wave clock and a one-cycle tick pulse come out of a programmable divider that runs on the fast reference clock. A strap input picks 50 Hz or 60 Hz power-line operation. With the default parameters and a 16 MHz reference, that gives a heartbeat of about 1.667 kHz (divide by 9600) or 2 kHz (divide by 8000).

In locked mode the block measures the time between rising edges of a line-frequency reference input. It takes that period divided by a fixed multiplier (33 by default) as the divisor, so the heartbeat runs at about 33 times the line frequency. Each rising reference edge restarts the divider phase. If the reference goes quiet for twice the nominal line period, the block flags loss of lock and falls back to the free-running divisor until lock is regained.

Top module: `line_tick_gen`

## Requirements
- R1: With `lock_en` low and `sel_60hz` low, `tick_pulse` repeats every DIV_50 clock cycles and `tick_clk` is high for DIV_50/2 of them.
- R2: With `lock_en` low and `sel_60hz` high, `tick_pulse` repeats every DIV_60 clock cycles and `tick_clk` is high for DIV_60/2 of them.
- R3: A change of `sel_60hz` takes effect only at a divider wrap: the period in progress finishes at its old length and the next one has the new length.
- R4: `tick_pulse` is never high on two consecutive cycles, and it is high only in a cycle where `tick_clk` is high; in free-running mode it marks the first high cycle of each `tick_clk` period.
- R5: In locked mode, once two rising reference edges have been seen, the divisor becomes floor(P / MULT), where P is the number of clock cycles between the last two rising edges of `line_ref`; it is applied from the next wrap or restart.
- R6: In locked mode, each rising edge of `line_ref` restarts the divider: `tick_pulse` is high 3 clock cycles after the cycle in which `line_ref` first reads high (two synchronizer stages plus the output register).
- R7: In locked mode, if no rising reference edge is seen for 2 x LINE_50 cycles (strap at 50 Hz) or 2 x LINE_60 cycles (strap at 60 Hz), `lock_lost` goes high and the divider returns to the free-running divisor of R1 or R2.
- R8: After a loss of lock, `lock_lost` clears on the next rising reference edge, and the locked divisor returns only after the edge that follows it.
- R9: With `lock_en` low, `line_ref` has no effect on the tick outputs and `lock_lost` stays low.
- R10: While `rst_n` is low at a clock edge, `tick_clk`, `tick_pulse` and `lock_lost` are all 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_60hz | input | 1 | Line-frequency strap: 0 = 50 Hz, 1 = 60 Hz |
| lock_en | input | 1 | 1 = lock the heartbeat to the line reference |
| line_ref | input | 1 | Asynchronous line-frequency reference square wave |
| tick_clk | output | 1 | Heartbeat square wave |
| tick_pulse | output | 1 | One-cycle pulse at the start of each heartbeat period |
| lock_lost | output | 1 | Locked mode has lost the line reference |

## Verification
Divider results are checked over whole periods. The bench counts the sampled cycles between two tick pulses and the high cycles of `tick_clk` in that window, so the output register latency cancels out. After a strap change, the period in progress and the one after it are each measured. Locked-mode results come 3 cycles after a reference rise (R6), and a new divisor is due only once two edges have been measured, so every locked check reads intervals from the last of four line periods, when the divisor has settled. The timeout is probed about 50 cycles before and after its due point of 2 x LINE_50 + 3 cycles past the last rise.

// File: rtl/line_tick_pkg.sv
// Package: shared types and helpers for the line-synchronous tick generator.
// Assumes: nothing beyond IEEE 1800-2017.
package line_tick_pkg;

    // Source of the divisor loaded at the next wrap or restart.
    typedef enum logic [1:0] {
        SRC_FREE_50 = 2'd0,
        SRC_FREE_60 = 2'd1,
        SRC_LOCKED  = 2'd2
    } div_src_e;

    // Largest of three non-negative values, for width derivation.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/line_edge_sync.sv
// Module: line_edge_sync
// Brings the asynchronous line reference into the clock domain through two
// flops and reports a one-cycle pulse on each rising edge.
// Assumes: the reference is far slower than clk.
module line_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_ref,
    output logic rise
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-stage synchronizer followed by a delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= line_ref;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

    // R6: a detected edge lasts exactly one cycle.
    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/line_period_meter.sv
// Module: line_period_meter
// Measures the line period as a count of MULT-cycle groups (which gives the
// period divided by MULT without a divider) and watches for a missing edge.
// Assumes: MULT >= 2; QW holds 2*max(LINE_50, LINE_60)/MULT.
module line_period_meter #(
    parameter int MULT    = 33,
    parameter int LINE_50 = 320000,
    parameter int LINE_60 = 266667,
    parameter int QW      = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          sel_60hz,
    input  logic          rise,
    output logic [QW-1:0] quot,
    output logic          valid,
    output logic          lost
);
    localparam int SW = (MULT > 2) ? $clog2(MULT) : 1;
    localparam int TW = $clog2(2 * ((LINE_50 > LINE_60) ? LINE_50 : LINE_60) + 1);
    localparam logic [TW-1:0] LIM_50  = TW'(2 * LINE_50);
    localparam logic [TW-1:0] LIM_60  = TW'(2 * LINE_60);
    localparam logic [SW-1:0] SUB_TOP = SW'(MULT - 1);

    logic [SW-1:0] sub_q;
    logic [QW-1:0] grp_q;
    logic [TW-1:0] elapsed_q;
    logic          seen_q;
    logic [TW-1:0] limit;

    assign limit = sel_60hz ? LIM_60 : LIM_50;

    // Count groups between edges, publish the result, time out a quiet line.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            sub_q     <= '0;
            grp_q     <= '0;
            elapsed_q <= '0;
            seen_q    <= 1'b0;
            quot      <= '0;
            valid     <= 1'b0;
            lost      <= 1'b0;
        end else if (rise) begin
            sub_q     <= SW'(1);
            grp_q     <= '0;
            elapsed_q <= '0;
            seen_q    <= 1'b1;
            lost      <= 1'b0;
            if (seen_q && !lost && grp_q >= QW'(2)) begin
                quot  <= grp_q;
                valid <= 1'b1;
            end
        end else if (!lost) begin
            elapsed_q <= elapsed_q + TW'(1);
            if (sub_q == SUB_TOP) begin
                sub_q <= '0;
                grp_q <= grp_q + QW'(1);
            end else begin
                sub_q <= sub_q + SW'(1);
            end
            if (elapsed_q >= limit - TW'(1)) begin
                lost  <= 1'b1;
                valid <= 1'b0;
            end
        end
    end

    // R7: a lost line never leaves a locked divisor in use.
    assert_lost_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> !valid);
    // R8: an edge during loss clears the flag on the next cycle.
    assert_lost_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && rise && enable) |=> !lost);
    // R8: the edge that clears loss does not yet produce a locked divisor.
    assert_relock_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && rise) |=> !valid);
    // R9: outside locked mode nothing is flagged or published.
    assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!lost && !valid));

endmodule

// File: rtl/tick_divider.sv
// Module: tick_divider
// Divides clk by a divisor sampled only at a wrap or restart, and drives a
// registered square wave and a one-cycle tick at the start of each period.
// Assumes: div_next >= 2.
module tick_divider #(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] div_next,
    input  logic          restart,
    output logic          tick_clk,
    output logic          tick_pulse
);
    logic [CW-1:0] count_q;
    logic [CW-1:0] div_q;
    logic [CW-1:0] nxt_count;
    logic [CW-1:0] nxt_div;
    logic          wrap;
    logic          load;

    // Decide whether this cycle ends a period and what the next state is.
    always_comb begin
        wrap      = (count_q >= div_q - CW'(1));
        load      = wrap || (restart && count_q != '0);
        nxt_count = load ? '0 : count_q + CW'(1);
        nxt_div   = load ? div_next : div_q;
    end

    // Advance the counter and register both outputs from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q    <= '0;
            div_q      <= div_next;
            tick_clk   <= 1'b0;
            tick_pulse <= 1'b0;
        end else begin
            count_q    <= nxt_count;
            div_q      <= nxt_div;
            tick_clk   <= (nxt_count < (nxt_div >> 1));
            tick_pulse <= load;
        end
    end

    // R4: ticks are isolated cycles.
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);
    // R4: a tick always falls in the high phase of the square wave.
    assert_pulse_in_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |-> tick_clk);
    // R3: the active divisor changes only where a new period begins.
    assert_div_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q) |-> tick_pulse);

endmodule

// File: rtl/line_tick_gen.sv
// Module: line_tick_gen (top)
// System heartbeat generator: free-running divider chosen by the line strap,
// or a divider slaved to the measured line period when locking is enabled.
// Assumes: line_ref is asynchronous; DIV_50/DIV_60 even and >= 2.
module line_tick_gen #(
    parameter int DIV_50  = 9600,
    parameter int DIV_60  = 8000,
    parameter int LINE_50 = 320000,
    parameter int LINE_60 = 266667,
    parameter int MULT    = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_60hz,
    input  logic lock_en,
    input  logic line_ref,
    output logic tick_clk,
    output logic tick_pulse,
    output logic lock_lost
);
    import line_tick_pkg::*;

    localparam int QMAX = 2 * ((LINE_50 > LINE_60) ? LINE_50 : LINE_60) / MULT + 1;
    localparam int CW   = $clog2(max3(DIV_50, DIV_60, QMAX) + 1);

    logic          rise;
    logic [CW-1:0] quot;
    logic          quot_valid;
    logic          lost;
    logic [CW-1:0] div_next;
    div_src_e      src;

    line_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_ref (line_ref),
        .rise     (rise)
    );

    line_period_meter #(
        .MULT    (MULT),
        .LINE_50 (LINE_50),
        .LINE_60 (LINE_60),
        .QW      (CW)
    ) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (lock_en),
        .sel_60hz (sel_60hz),
        .rise     (rise),
        .quot     (quot),
        .valid    (quot_valid),
        .lost     (lost)
    );

    // Choose where the next divisor comes from and fetch it.
    always_comb begin
        if (lock_en && quot_valid) src = SRC_LOCKED;
        else if (sel_60hz)         src = SRC_FREE_60;
        else                       src = SRC_FREE_50;
        case (src)
            SRC_LOCKED:  div_next = quot;
            SRC_FREE_60: div_next = CW'(DIV_60);
            default:     div_next = CW'(DIV_50);
        endcase
    end

    tick_divider #(
        .CW (CW)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_next   (div_next),
        .restart    (lock_en && rise),
        .tick_clk   (tick_clk),
        .tick_pulse (tick_pulse)
    );

    assign lock_lost = lost;

    // R5: a locked divisor handed to the divider is always usable.
    assert_locked_div_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_LOCKED) |-> (div_next >= CW'(2)));
    // R10: reset clears every output on the following cycle.
    assert_reset_outputs_R10: assert property (@(posedge clk)
        !rst_n |=> (!tick_clk && !tick_pulse && !lock_lost));

endmodule

// File: tb/line_tick_gen_bench.sv
// Bench for line_tick_gen with scaled-down divisors and line periods.
module line_tick_gen_bench;
    localparam int DIV50 = 48;
    localparam int DIV60 = 40;
    localparam int LN50  = 1600;
    localparam int LN60  = 1334;
    localparam int MUL   = 33;

    // Free-running vectors: strap, expected period, expected high cycles.
    localparam int NFREE = 4;
    localparam int FREE_VEC [0:NFREE-1][0:2] = '{
        '{0, DIV50, DIV50/2},
        '{1, DIV60, DIV60/2},
        '{0, DIV50, DIV50/2},
        '{1, DIV60, DIV60/2}
    };
    // Locked vectors: line period, expected max interval, expected min interval.
    localparam int NLOCK = 3;
    localparam int LOCK_VEC [0:NLOCK-1][0:2] = '{
        '{1650, 1650/MUL, 1650/MUL},
        '{1700, 1700/MUL, 1700 - (1700/MUL)*(1700/(1700/MUL) - 1) - (1700/MUL)},
        '{1584, 1584/MUL, 1584/MUL}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_60hz = 1'b0;
    logic lock_en = 1'b0;
    logic line_ref = 1'b0;
    logic tick_clk;
    logic tick_pulse;
    logic lock_lost;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    line_tick_gen #(
        .DIV_50 (DIV50), .DIV_60 (DIV60),
        .LINE_50 (LN50), .LINE_60 (LN60), .MULT (MUL)
    ) u_line_tick_gen (
        .clk (clk), .rst_n (rst_n), .sel_60hz (sel_60hz), .lock_en (lock_en),
        .line_ref (line_ref), .tick_clk (tick_clk), .tick_pulse (tick_pulse),
        .lock_lost (lock_lost)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sync_pulse();
        do @(negedge clk); while (!tick_pulse);
    endtask

    // From a pulse cycle, count the period and its high cycles up to the next pulse.
    task automatic period(output int per, output int hi);
        per = 0; hi = 0;
        do begin
            if (tick_clk) hi++;
            per++;
            @(negedge clk);
        end while (!tick_pulse);
    endtask

    // Drive n line periods of length p; report stats of the last period.
    task automatic run_line(input int p, input int n, output int mx, output int mn,
                            output int offs);
        int cyc;
        int last_p;
        int rise_c;
        bit got_off;
        cyc = 0; last_p = -1; rise_c = 0; mx = 0; mn = 1 << 30; offs = -1; got_off = 0;
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < p; j++) begin
                @(negedge clk);
                cyc++;
                if (tick_pulse) begin
                    if (k == n - 1 && last_p >= 0) begin
                        if (cyc - last_p > mx) mx = cyc - last_p;
                        if (cyc - last_p < mn) mn = cyc - last_p;
                    end
                    if (k == n - 1 && !got_off && cyc > rise_c) begin
                        offs = cyc - rise_c;
                        got_off = 1;
                    end
                    last_p = cyc;
                end
                line_ref = (j < p / 2);
                if (j == 0) rise_c = cyc;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int per, hi, mx, mn, offs;

        // R10: outputs cleared while reset is held.
        wait_cyc(3);
        check("R10 tick_clk in reset", int'(tick_clk), 0);
        check("R10 tick_pulse in reset", int'(tick_pulse), 0);
        check("R10 lock_lost in reset", int'(lock_lost), 0);
        rst_n = 1'b1;

        // R1/R2/R4: free-running vector walk.
        for (int v = 0; v < NFREE; v++) begin
            sel_60hz = FREE_VEC[v][0][0];
            sync_pulse();
            sync_pulse();
            period(per, hi);
            check(FREE_VEC[v][0] != 0 ? "R2 free period" : "R1 free period", per, FREE_VEC[v][1]);
            check(FREE_VEC[v][0] != 0 ? "R2 free high" : "R1 free high", hi, FREE_VEC[v][2]);
            check("R4 pulse in first high cycle", int'(tick_clk), 1);
        end

        // R3: strap flipped mid-period takes effect only after the wrap.
        sel_60hz = 1'b0;
        sync_pulse(); sync_pulse();
        per = 0;
        do begin
            per++;
            if (per == 10) sel_60hz = 1'b1;
            @(negedge clk);
        end while (!tick_pulse);
        check("R3 old period kept", per, DIV50);
        period(per, hi);
        check("R3 new period after wrap", per, DIV60);
        per = 0;
        do begin
            per++;
            if (per == 5) sel_60hz = 1'b0;
            @(negedge clk);
        end while (!tick_pulse);
        check("R3 old period kept back", per, DIV60);
        period(per, hi);
        check("R3 new period back", per, DIV50);

        // R9: line reference ignored while locking is off.
        run_line(1000, 3, mx, mn, offs);
        check("R9 max interval unlocked", mx, DIV50);
        check("R9 min interval unlocked", mn, DIV50);
        check("R9 lock_lost low", int'(lock_lost), 0);

        // R5/R6: locked vector walk.
        lock_en = 1'b1;
        for (int v = 0; v < NLOCK; v++) begin
            run_line(LOCK_VEC[v][0], 4, mx, mn, offs);
            check("R5 locked max interval", mx, LOCK_VEC[v][1]);
            check("R5 locked min interval", mn, LOCK_VEC[v][2]);
            check("R6 pulse after reference rise", offs, 3);
            check("R7 no loss while locked", int'(lock_lost), 0);
        end

        // R7: quiet line times out after twice the nominal period.
        line_ref = 1'b0;
        wait_cyc(2 * LN50 - 1584 - 50);
        check("R7 not lost before limit", int'(lock_lost), 0);
        wait_cyc(100);
        check("R7 lost after limit", int'(lock_lost), 1);
        sync_pulse(); sync_pulse();
        period(per, hi);
        check("R7 fallback period", per, DIV50);
        check("R7 fallback high", hi, DIV50 / 2);

        // R8: one edge clears loss but keeps the free divisor; lock returns later.
        run_line(1650, 1, mx, mn, offs);
        check("R8 loss cleared by edge", int'(lock_lost), 0);
        check("R8 still free divisor", mx, DIV50);
        run_line(1650, 3, mx, mn, offs);
        check("R8 relocked max", mx, 50);
        check("R8 relocked min", mn, 50);

        // R10: reset in mid operation.
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(2);
        check("R10 tick_clk mid reset", int'(tick_clk), 0);
        check("R10 tick_pulse mid reset", int'(tick_pulse), 0);
        check("R10 lock_lost mid reset", int'(lock_lost), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule